// File: doc/BRIEF.md
# Security-Banked Interrupt Control Register File

This block is the small register file that sits behind the configuration port of an interrupt controller serving a system with two security states. Every bus access carries a flag saying whether it comes from the secure or the non-secure world. The block uses that flag to choose which copy of a register the access reaches, and to decide what the access may see or change. The enables, masks, group assignments and priority fields it holds are driven out continuously to the rest of the controller.

The register types differ in how they treat the flag. Control words have a separate view for each world. The group-1 enable is one flop that appears at a different bit in each view. The priority mask has two fully independent copies. The group assignment word can be reached only from the secure world. The priority fields are shared by both worlds, but a non-secure access sees them through a one-bit shift, and an interrupt assigned to group 0 is hidden from it. A write takes effect at the clock edge on which it is presented. Read data appears, with a valid strobe, on the cycle after the read request.

Top module: `sec_bank_regs`

## Requirements
- R1: After reset every exported enable, mask, group bit and priority field is 0. `rvalid` is 0, and so is `rdata`. This includes the group-1 enable bits that the non-secure view can reach.
- R2: A read request (`req`=1, `wr`=0) gives `rvalid`=1 and its data on `rdata` in the following cycle. In any cycle after a cycle with no read request, `rvalid` and `rdata` are 0. A write is visible on the exported outputs in the cycle after it is presented.
- R3: The distributor control word is at word address 0. The secure view holds the group-0 forward enable at bit 0 and the group-1 forward enable at bit 1. The non-secure view shows only the group-1 forward enable, at bit 0. A non-secure write can change only that bit.
- R4: The interface control word is at word address 1. The secure view holds the group-0 signal enable at bit 0, the group-1 signal enable at bit 1 and the acknowledge-control bit at bit 2. The non-secure view shows only the group-1 signal enable, at bit 0. A non-secure write leaves the group-0 enable and the acknowledge-control bit unchanged.
- R5: The priority mask at word address 2 has two independent 8-bit copies in bits 7:0. Secure accesses read and write only the secure copy. Non-secure accesses read and write only the non-secure copy.
- R6: The identification word at word address 3 reads bit 0 = 1 (two security states supported), bits 15:8 = NUM_PRIO and all other bits 0, in both worlds. Writes to it have no effect.
- R7: The group assignment word at word address 4 is secure-only. Bit i = 1 puts interrupt i in group 1. Non-secure reads return 0 and non-secure writes have no effect.
- R8: Priority field i is at word address 8+i, in bits 7:0. Secure accesses read and write it unchanged. When group bit i is 1, a non-secure read returns the field shifted left by one with bit 0 cleared. A non-secure write of value w stores {1, w[7:1]}.
- R9: When group bit i is 0, a non-secure read of priority field i returns 0 and a non-secure write leaves it unchanged.
- R10: Word addresses 5 to 7 and 8+NUM_PRIO upward are not implemented. Reads of them return 0 in both worlds, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| nonSec | input | 1 | 1 = non-secure access, 0 = secure access |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one cycle after the request |
| rvalid | output | 1 | Read data valid |
| grp0Fwd | output | 1 | Group-0 forward enable |
| grp1Fwd | output | 1 | Group-1 forward enable |
| sigGrp0 | output | 1 | Group-0 signal enable |
| sigGrp1 | output | 1 | Group-1 signal enable |
| ackCtl | output | 1 | Acknowledge-control bit |
| secPmask | output | PRIO_W | Secure priority mask copy |
| nsPmask | output | PRIO_W | Non-secure priority mask copy |
| grpBits | output | NUM_PRIO | Group assignment, bit i = interrupt i in group 1 |
| prioVec | output | NUM_PRIO*PRIO_W | Priority fields, field i in bits [i*PRIO_W +: PRIO_W] |

## Verification
The hardest case to reach is the shifted non-secure view of a priority field. A non-secure access sees a priority field only after a secure write has put that interrupt in group 1. Under reset defaults every non-secure priority access is therefore read-as-zero. To reach the shifted view, the stimulus first makes secure writes to the group word that mark some interrupts group 1 and leave others in group 0. It then mixes secure and non-secure accesses to the same priority fields, so that one sequence covers both the shifted path and the hidden path. A long pseudo-random phase follows. It draws addresses from the whole space and flips the security flag on each access, while the group word keeps changing underneath.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  // word address map; the priority block starts at PRIO_BASE
  localparam int A_DIST    = 0;
  localparam int A_CPU     = 1;
  localparam int A_PMASK   = 2;
  localparam int A_TYPE    = 3;
  localparam int A_GRP     = 4;
  localparam int PRIO_BASE = 8;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_DIST, SEL_CPU, SEL_PMS, SEL_PMN, SEL_TYPE, SEL_GRP, SEL_PRIO
  } rdSel_e;

  // strobes from decode to storage
  typedef struct packed {
    logic   wrDist;
    logic   wrCpu;
    logic   wrPmask;
    logic   wrGrp;
    logic   wrPrio;
    logic   rdEn;
    logic   nonSec;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/sbr_ctrl.sv
module sbr_ctrl #(
  parameter int ADDR_W   = 5,
  parameter int NUM_PRIO = 4,
  parameter int IDX_W    = 2
) (
  input  logic                req,
  input  logic                wr,
  input  logic                nonSec,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PRIO-1:0] grpBits,
  output sbr_pkg::strobe_t    stb,
  output logic [IDX_W-1:0]    prioIdx
);
  import sbr_pkg::*;

  localparam logic [ADDR_W-1:0] L_DIST  = ADDR_W'(A_DIST);
  localparam logic [ADDR_W-1:0] L_CPU   = ADDR_W'(A_CPU);
  localparam logic [ADDR_W-1:0] L_PMASK = ADDR_W'(A_PMASK);
  localparam logic [ADDR_W-1:0] L_TYPE  = ADDR_W'(A_TYPE);
  localparam logic [ADDR_W-1:0] L_GRP   = ADDR_W'(A_GRP);
  localparam logic [ADDR_W-1:0] L_PBASE = ADDR_W'(PRIO_BASE);
  localparam logic [ADDR_W-1:0] L_PNUM  = ADDR_W'(NUM_PRIO);

  logic [ADDR_W-1:0] offs;
  logic              inPrio;
  logic              doWr;

  assign offs    = addr - L_PBASE;
  assign inPrio  = (addr >= L_PBASE) && (offs < L_PNUM);
  assign prioIdx = offs[IDX_W-1:0];
  assign doWr    = req && wr;

  always_comb begin
    stb        = '0;
    stb.rdSel  = SEL_ZERO;
    stb.nonSec = nonSec;
    stb.rdEn   = req && !wr;
    if (addr == L_DIST) begin
      stb.rdSel  = SEL_DIST;
      stb.wrDist = doWr;
    end else if (addr == L_CPU) begin
      stb.rdSel  = SEL_CPU;
      stb.wrCpu  = doWr;
    end else if (addr == L_PMASK) begin
      stb.rdSel   = nonSec ? SEL_PMN : SEL_PMS;
      stb.wrPmask = doWr;
    end else if (addr == L_TYPE) begin
      stb.rdSel  = SEL_TYPE;
    end else if (addr == L_GRP) begin
      if (!nonSec) begin
        stb.rdSel = SEL_GRP;
        stb.wrGrp = doWr;
      end
    end else if (inPrio) begin
      // non-secure reaches only group-1 fields
      if (!nonSec || grpBits[prioIdx]) begin
        stb.rdSel  = SEL_PRIO;
        stb.wrPrio = doWr;
      end
    end
  end

endmodule

// File: rtl/sbr_dpath.sv
module sbr_dpath #(
  parameter int DATA_W   = 32,
  parameter int NUM_PRIO = 4,
  parameter int PRIO_W   = 8,
  parameter int IDX_W    = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  sbr_pkg::strobe_t           stb,
  input  logic [IDX_W-1:0]           prioIdx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rvalid,
  output logic                       grp0Fwd,
  output logic                       grp1Fwd,
  output logic                       sigGrp0,
  output logic                       sigGrp1,
  output logic                       ackCtl,
  output logic [PRIO_W-1:0]          secPmask,
  output logic [PRIO_W-1:0]          nsPmask,
  output logic [NUM_PRIO-1:0]        grpBits,
  output logic [NUM_PRIO*PRIO_W-1:0] prioVec
);
  import sbr_pkg::*;

  logic [DATA_W-1:0] rdNext;
  logic [PRIO_W-1:0] prioSel;
  logic              unusedOk;

  assign unusedOk = ^wdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grp0Fwd  <= 1'b0;
      grp1Fwd  <= 1'b0;
      sigGrp0  <= 1'b0;
      sigGrp1  <= 1'b0;
      ackCtl   <= 1'b0;
      secPmask <= '0;
      nsPmask  <= '0;
      grpBits  <= '0;
    end else begin
      if (stb.wrDist) begin
        if (stb.nonSec) grp1Fwd <= wdata[0];
        else begin
          grp0Fwd <= wdata[0];
          grp1Fwd <= wdata[1];
        end
      end
      if (stb.wrCpu) begin
        if (stb.nonSec) sigGrp1 <= wdata[0];
        else begin
          sigGrp0 <= wdata[0];
          sigGrp1 <= wdata[1];
          ackCtl  <= wdata[2];
        end
      end
      if (stb.wrPmask) begin
        if (stb.nonSec) nsPmask  <= wdata[PRIO_W-1:0];
        else            secPmask <= wdata[PRIO_W-1:0];
      end
      if (stb.wrGrp) grpBits <= wdata[NUM_PRIO-1:0];
    end
  end

  // one register per priority field
  for (genvar i = 0; i < NUM_PRIO; i++) begin : g_prio
    logic [PRIO_W-1:0] pr;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pr <= '0;
      else if (stb.wrPrio && prioIdx == IDX_W'(i))
        pr <= stb.nonSec ? {1'b1, wdata[PRIO_W-1:1]} : wdata[PRIO_W-1:0];
    end
    assign prioVec[i*PRIO_W +: PRIO_W] = pr;
  end

  assign prioSel = prioVec[prioIdx*PRIO_W +: PRIO_W];

  always_comb begin
    case (stb.rdSel)
      SEL_DIST: rdNext = stb.nonSec ? DATA_W'(grp1Fwd) : DATA_W'({grp1Fwd, grp0Fwd});
      SEL_CPU:  rdNext = stb.nonSec ? DATA_W'(sigGrp1)
                                    : DATA_W'({ackCtl, sigGrp1, sigGrp0});
      SEL_PMS:  rdNext = DATA_W'(secPmask);
      SEL_PMN:  rdNext = DATA_W'(nsPmask);
      SEL_TYPE: rdNext = DATA_W'({8'(NUM_PRIO), 7'b0, 1'b1});
      SEL_GRP:  rdNext = DATA_W'(grpBits);
      SEL_PRIO: rdNext = stb.nonSec ? DATA_W'({prioSel[PRIO_W-2:0], 1'b0})
                                    : DATA_W'(prioSel);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= stb.rdEn;
      rdata  <= stb.rdEn ? rdNext : '0;
    end
  end

endmodule

// File: rtl/sec_bank_regs.sv
module sec_bank_regs #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int NUM_PRIO = 4,
  parameter int PRIO_W   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       req,
  input  logic                       wr,
  input  logic                       nonSec,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rvalid,
  output logic                       grp0Fwd,
  output logic                       grp1Fwd,
  output logic                       sigGrp0,
  output logic                       sigGrp1,
  output logic                       ackCtl,
  output logic [PRIO_W-1:0]          secPmask,
  output logic [PRIO_W-1:0]          nsPmask,
  output logic [NUM_PRIO-1:0]        grpBits,
  output logic [NUM_PRIO*PRIO_W-1:0] prioVec
);
  localparam int IDX_W = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1;

  sbr_pkg::strobe_t   stb;
  logic [IDX_W-1:0]   prioIdx;

  sbr_ctrl #(.ADDR_W(ADDR_W), .NUM_PRIO(NUM_PRIO), .IDX_W(IDX_W)) u_ctrl (
    .req(req), .wr(wr), .nonSec(nonSec), .addr(addr), .grpBits(grpBits),
    .stb(stb), .prioIdx(prioIdx)
  );

  sbr_dpath #(.DATA_W(DATA_W), .NUM_PRIO(NUM_PRIO), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .prioIdx(prioIdx), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .grp0Fwd(grp0Fwd), .grp1Fwd(grp1Fwd),
    .sigGrp0(sigGrp0), .sigGrp1(sigGrp1), .ackCtl(ackCtl),
    .secPmask(secPmask), .nsPmask(nsPmask), .grpBits(grpBits), .prioVec(prioVec)
  );

endmodule

// File: rtl/sbr_chk.sv
module sbr_chk #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int NUM_PRIO = 4,
  parameter int PRIO_W   = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       req,
  input logic                       wr,
  input logic                       nonSec,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          wdata,
  input logic [DATA_W-1:0]          rdata,
  input logic                       rvalid,
  input logic                       grp0Fwd,
  input logic                       sigGrp0,
  input logic                       ackCtl,
  input logic [PRIO_W-1:0]          secPmask,
  input logic [PRIO_W-1:0]          nsPmask,
  input logic [NUM_PRIO-1:0]        grpBits,
  input logic [NUM_PRIO*PRIO_W-1:0] prioVec
);
  import sbr_pkg::*;

  localparam logic [ADDR_W-1:0] C_DIST  = ADDR_W'(A_DIST);
  localparam logic [ADDR_W-1:0] C_CPU   = ADDR_W'(A_CPU);
  localparam logic [ADDR_W-1:0] C_PMASK = ADDR_W'(A_PMASK);
  localparam logic [ADDR_W-1:0] C_TYPE  = ADDR_W'(A_TYPE);
  localparam logic [ADDR_W-1:0] C_GRP   = ADDR_W'(A_GRP);
  localparam logic [ADDR_W-1:0] C_PBASE = ADDR_W'(PRIO_BASE);
  localparam logic [ADDR_W-1:0] C_PEND  = ADDR_W'(PRIO_BASE + NUM_PRIO);

  logic isRd, isWr, unimpl, inPrio;
  assign isRd   = req && !wr;
  assign isWr   = req && wr;
  assign inPrio = (addr >= C_PBASE) && (addr < C_PEND);
  assign unimpl = (addr > C_GRP) && !inPrio;

  // R2
  rd_valid_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRd |=> rvalid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isRd |=> (!rvalid && rdata == '0));
  // R3
  ns_dist_keeps_grp0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && nonSec && addr == C_DIST) |=> $stable(grp0Fwd));
  // R4
  ns_cpu_keeps_secure_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && nonSec && addr == C_CPU) |=> ($stable(sigGrp0) && $stable(ackCtl)));
  // R5
  sec_pmask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && !nonSec && addr == C_PMASK) |=>
      (secPmask == $past(wdata[PRIO_W-1:0]) && $stable(nsPmask)));
  // R6
  type_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && addr == C_TYPE) |=> rdata[0]);
  // R7
  ns_grp_raz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && nonSec && addr == C_GRP) |=> rdata == '0);
  // R7
  ns_grp_wi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && nonSec && addr == C_GRP) |=> $stable(grpBits));
  // R9
  ns_grp0_prio_wi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && nonSec && inPrio && !grpBits[addr - C_PBASE]) |=> $stable(prioVec));
  // R10
  unimpl_raz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && unimpl) |=> rdata == '0);

endmodule

bind sec_bank_regs sbr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PRIO(NUM_PRIO), .PRIO_W(PRIO_W)
) u_chk (.*);

// File: tb/tb_sec_bank_regs.sv
`timescale 1ns/1ps
module tb_sec_bank_regs;
  localparam int ADDR_W = 5, DATA_W = 32, NP = 4, PW = 8;

  logic clk = 1'b0, rstN = 1'b0, req = 1'b0, wr = 1'b0, nonSec = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic rvalid, grp0Fwd, grp1Fwd, sigGrp0, sigGrp1, ackCtl;
  logic [PW-1:0] secPmask, nsPmask;
  logic [NP-1:0] grpBits;
  logic [NP*PW-1:0] prioVec;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  bit mG0, mG1, mC0, mC1, mAck;
  int mPs, mPn, mGrp;
  int mPrio[NP];
  bit expValid;
  int expRd;

  always #2.5 clk = ~clk;

  sec_bank_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PRIO(NP), .PRIO_W(PW)) dut (
    .clk(clk), .rstN(rstN), .req(req), .wr(wr), .nonSec(nonSec), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .grp0Fwd(grp0Fwd),
    .grp1Fwd(grp1Fwd), .sigGrp0(sigGrp0), .sigGrp1(sigGrp1), .ackCtl(ackCtl),
    .secPmask(secPmask), .nsPmask(nsPmask), .grpBits(grpBits), .prioVec(prioVec)
  );

  function automatic int mRead(bit ns, int a);
    int i;
    case (a)
      0: return ns ? int'(mG1) : int'({mG1, mG0});
      1: return ns ? int'(mC1) : int'({mAck, mC1, mC0});
      2: return ns ? mPn : mPs;
      3: return (NP << 8) | 1;
      4: return ns ? 0 : mGrp;
      default: begin
        if (a >= 8 && a < 8 + NP) begin
          i = a - 8;
          if (!ns) return mPrio[i];
          if (mGrp[i]) return (mPrio[i] << 1) & 255;
        end
        return 0;
      end
    endcase
  endfunction

  task automatic mWrite(bit ns, int a, int d);
    int i;
    case (a)
      0: if (ns) mG1 = d[0]; else begin mG0 = d[0]; mG1 = d[1]; end
      1: if (ns) mC1 = d[0]; else begin mC0 = d[0]; mC1 = d[1]; mAck = d[2]; end
      2: if (ns) mPn = d & 255; else mPs = d & 255;
      4: if (!ns) mGrp = d & ((1 << NP) - 1);
      default: if (a >= 8 && a < 8 + NP) begin
        i = a - 8;
        if (!ns) mPrio[i] = d & 255;
        else if (mGrp[i]) mPrio[i] = 128 | ((d & 255) >> 1);
      end
    endcase
  endtask

  task automatic compare(string tag);
    logic [DATA_W+1+5+2*PW+NP+NP*PW-1:0] act, exp;
    logic [NP*PW-1:0] ep;
    for (int i = 0; i < NP; i++) ep[i*PW +: PW] = PW'(mPrio[i]);
    act = {rvalid, rdata, grp0Fwd, grp1Fwd, sigGrp0, sigGrp1, ackCtl,
           secPmask, nsPmask, grpBits, prioVec};
    exp = {expValid, (expValid ? DATA_W'(expRd) : DATA_W'(0)), mG0, mG1, mC0, mC1, mAck,
           PW'(mPs), PW'(mPn), NP'(mGrp), ep};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access; called at a falling edge, returns at the next falling edge
  task automatic acc(bit w, bit ns, int a, int d, string tag);
    req = 1'b1; wr = w; nonSec = ns; addr = ADDR_W'(a); wdata = DATA_W'(d);
    expValid = !w;
    expRd = w ? 0 : mRead(ns, a);
    @(negedge clk);
    if (w) mWrite(ns, a, d);
    req = 1'b0;
    compare(tag);
  endtask

  task automatic idle(string tag);
    req = 1'b0;
    expValid = 1'b0;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mG0 = 0; mG1 = 0; mC0 = 0; mC1 = 0; mAck = 0; mPs = 0; mPn = 0; mGrp = 0;
    for (int i = 0; i < NP; i++) mPrio[i] = 0;
    expValid = 0; expRd = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle("R1 reset state");
    acc(0, 1, 0, 0, "R1 ns dist after reset");
    acc(0, 1, 1, 0, "R1 ns cpu after reset");
    acc(0, 0, 2, 0, "R1 secure pmask after reset");
    idle("R2 idle after read");

    // distributor control, R3
    acc(1, 0, 0, 3, "R3 secure write both enables");
    acc(0, 1, 0, 0, "R3 ns view bit0");
    acc(0, 0, 0, 0, "R3 secure view");
    acc(1, 1, 0, 32'hFFFF_FFFE, "R3 ns write clears group1 only");
    acc(0, 0, 0, 0, "R3 secure view after ns write");

    // interface control, R4
    acc(1, 0, 1, 7, "R4 secure write all bits");
    acc(0, 1, 1, 0, "R4 ns view");
    acc(1, 1, 1, 32'hFFFF_FFF8, "R4 ns write keeps secure bits");
    acc(0, 0, 1, 0, "R4 secure view after ns write");

    // priority mask copies, R5
    acc(1, 0, 2, 32'hA5, "R5 secure copy write");
    acc(1, 1, 2, 32'h3C, "R5 ns copy write");
    acc(0, 0, 2, 0, "R5 secure copy read");
    acc(0, 1, 2, 0, "R5 ns copy read");

    // identification word, R6
    acc(0, 0, 3, 0, "R6 secure read");
    acc(1, 0, 3, -1, "R6 secure write ignored");
    acc(1, 1, 3, -1, "R6 ns write ignored");
    acc(0, 1, 3, 0, "R6 ns read");

    // group word, R7
    acc(1, 1, 4, 32'hF, "R7 ns write ignored");
    acc(0, 1, 4, 0, "R7 ns read zero");
    acc(1, 0, 4, 32'h5, "R7 secure write");
    acc(0, 0, 4, 0, "R7 secure read");

    // priorities, R8 / R9 (fields 0,2 group 1; 1,3 group 0)
    acc(1, 0, 8, 32'h40, "R8 secure write p0");
    acc(1, 0, 9, 32'h33, "R9 secure write p1");
    acc(0, 1, 8, 0, "R8 ns shifted read p0");
    acc(1, 1, 8, 32'h64, "R8 ns write p0");
    acc(0, 0, 8, 0, "R8 secure read p0");
    acc(0, 1, 9, 0, "R9 ns read group0 field");
    acc(1, 1, 9, 32'hFF, "R9 ns write group0 field ignored");
    acc(0, 0, 9, 0, "R9 secure read p1");
    acc(1, 0, 11, 32'hFF, "R8 secure write p3");
    acc(1, 1, 10, 32'h01, "R8 ns write p2 low bit dropped");
    idle("R2 idle after write");

    // unimplemented addresses, R10
    for (int a = 5; a < 32; a++) begin
      if (a >= 8 && a < 8 + NP) continue;
      acc(1, a[0], a, -1, "R10 write ignored");
      acc(0, a[1], a, 0, "R10 read zero");
    end

    // mixed pseudo-random phase over all rules
    for (int n = 0; n < 600; n++) begin
      int a, d;
      bit w, ns;
      a = int'($urandom_range(0, 15));
      d = int'($urandom);
      w = 1'($urandom_range(0, 1));
      ns = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 7) == 0) idle("R2 random idle");
      else acc(w, ns, a, d, "R2 R8 random access");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule